// File: doc/BRIEF.md
# Link Bring-Up Supervisor with Bounded Retry

This block watches over the bring-up of a single serial link port. When a start pulse arrives it waits for the port to report that its data link layer is up. It then waits for a second indication that the link is active. Each of the two waits has its own timeout, counted in millisecond ticks supplied from outside. If either wait runs out, the block drives the port reset high and holds it for a short, tick-counted interval. It then releases the reset and begins a fresh attempt.

After a fixed number of failed attempts the block gives up and reports failure. As soon as the second wait sees the link-active indication, the block reports success. The outcome it settles on stays on the outputs until the next start pulse. The physical layer and link training are outside the block. Only their status levels reach it.

Top module: `link_bringup_mon`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `link_up_o`, `link_failed_o` and `port_rst_o` are all low.
- R2: A `start_i` pulse begins a new attempt sequence only when no supervision is in progress (idle or an outcome is held). A pulse during supervision has no effect on the timing of the current wait.
- R3: The first wait ends with a move to the second wait in any cycle where `dl_up_i` is high. If TIMEOUT_TICKS ticks pass in that stage with `dl_up_i` low, the second wait is skipped and `port_rst_o` rises after the clock edge that accepts the last of those ticks.
- R4: The second wait ends with success in any cycle where `lnk_active_i` is high, and `link_up_o` goes high after that edge. If TIMEOUT_TICKS ticks pass without it, `port_rst_o` rises.
- R5: Each wait stage counts its timeout from the full TIMEOUT_TICKS, regardless of how many ticks the previous stage used.
- R6: `port_rst_o`, once raised, stays high over any number of cycles. It falls only after the edge that accepts the RST_HOLD_TICKS-th tick since it rose.
- R7: At most MAX_TRIES attempts are made. When the reset pulse that ends the last attempt falls, `link_failed_o` rises in the same cycle. Success inside the last attempt yields `link_up_o` and not failure.
- R8: If the awaited status is high in the same cycle as the tick that would end the wait, the status wins and no reset pulse follows.
- R9: An outcome (`link_up_o` or `link_failed_o`) holds regardless of ticks and status inputs until the next `start_i`. It clears after the edge that accepts that start. The two outcome outputs are never high together.
- R10: While supervision is in progress, both `link_up_o` and `link_failed_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that begins supervision |
| tick_i | input | 1 | One-cycle pulse once per millisecond |
| dl_up_i | input | 1 | Data link layer up status level |
| lnk_active_i | input | 1 | Link active status level |
| port_rst_o | output | 1 | Port reset, high during a retry pulse |
| link_up_o | output | 1 | Held high after a successful bring-up |
| link_failed_o | output | 1 | Held high after all attempts failed |

## Verification
A wait can end in two ways in the same cycle: the awaited status arrives, and the final tick of the timeout is accepted. The bench lets 199 ticks pass in a stage. It then raises the final tick together with the status in a single cycle, once in each wait stage. The verdict is correct when `port_rst_o` stays low and the block moves on: from the first wait to the second, or from the second to a held `link_up_o`.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAIT_DL = 3'd1,
    ST_WAIT_LA = 3'd2,
    ST_RST     = 3'd3,
    ST_OK      = 3'd4,
    ST_FAIL    = 3'd5
  } lbm_state_e;
endpackage

// File: rtl/lbm_tick_timer.sv
module lbm_tick_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expire
);
  logic [W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
    end else if (load) begin
      rem_q <= load_val;
    end else if (tick && (rem_q != '0)) begin
      rem_q <= rem_q - W'(1);
    end
  end

  // the tick that brings the remaining count from one to zero ends the window
  assign expire = tick && (rem_q == W'(1));
endmodule

// File: rtl/lbm_try_counter.sv
module lbm_try_counter #(
  parameter int unsigned MAX_TRIES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic incr,
  output logic last
);
  localparam int unsigned CW = $clog2(MAX_TRIES + 1);

  logic [CW-1:0] used_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q <= '0;
    end else if (clear) begin
      used_q <= CW'(1);
    end else if (incr && (used_q != CW'(MAX_TRIES))) begin
      used_q <= used_q + CW'(1);
    end
  end

  assign last = (used_q == CW'(MAX_TRIES));
endmodule

// File: rtl/link_bringup_mon.sv
module link_bringup_mon #(
  parameter int unsigned TIMEOUT_TICKS  = 200,
  parameter int unsigned RST_HOLD_TICKS = 1,
  parameter int unsigned MAX_TRIES      = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic tick_i,
  input  logic dl_up_i,
  input  logic lnk_active_i,
  output logic port_rst_o,
  output logic link_up_o,
  output logic link_failed_o
);
  import lbm_pkg::*;

  localparam int unsigned MAX_WIN = (TIMEOUT_TICKS > RST_HOLD_TICKS) ? TIMEOUT_TICKS : RST_HOLD_TICKS;
  localparam int unsigned TW      = $clog2(MAX_WIN + 1);
  localparam logic [TW-1:0] WAIT_LOAD = TW'(TIMEOUT_TICKS);
  localparam logic [TW-1:0] HOLD_LOAD = TW'(RST_HOLD_TICKS);

  lbm_state_e state_q, state_n;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_expire;
  logic          try_clear;
  logic          try_incr;
  logic          try_last;

  lbm_tick_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .tick     (tick_i),
    .expire   (tmr_expire)
  );

  lbm_try_counter #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk   (clk),
    .rst   (rst),
    .clear (try_clear),
    .incr  (try_incr),
    .last  (try_last)
  );

  always_comb begin
    state_n   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = WAIT_LOAD;
    try_clear = 1'b0;
    try_incr  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_OK, ST_FAIL: begin
        if (start_i) begin
          state_n   = ST_WAIT_DL;
          tmr_load  = 1'b1;
          try_clear = 1'b1;
        end
      end
      ST_WAIT_DL: begin
        // status is checked before the timeout, so a late arrival still counts
        if (dl_up_i) begin
          state_n  = ST_WAIT_LA;
          tmr_load = 1'b1;
        end else if (tmr_expire) begin
          state_n  = ST_RST;
          tmr_load = 1'b1;
          tmr_val  = HOLD_LOAD;
        end
      end
      ST_WAIT_LA: begin
        if (lnk_active_i) begin
          state_n = ST_OK;
        end else if (tmr_expire) begin
          state_n  = ST_RST;
          tmr_load = 1'b1;
          tmr_val  = HOLD_LOAD;
        end
      end
      ST_RST: begin
        if (tmr_expire) begin
          if (try_last) begin
            state_n = ST_FAIL;
          end else begin
            state_n  = ST_WAIT_DL;
            tmr_load = 1'b1;
            try_incr = 1'b1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      port_rst_o    <= 1'b0;
      link_up_o     <= 1'b0;
      link_failed_o <= 1'b0;
    end else begin
      state_q       <= state_n;
      port_rst_o    <= (state_n == ST_RST);
      link_up_o     <= (state_n == ST_OK);
      link_failed_o <= (state_n == ST_FAIL);
    end
  end
endmodule

// File: rtl/lbm_checker.sv
module lbm_checker (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic tick_i,
  input logic dl_up_i,
  input logic lnk_active_i,
  input logic port_rst_o,
  input logic link_up_o,
  input logic link_failed_o
);
  // R9: outcomes exclusive
  assert_outcome_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(link_up_o && link_failed_o));

  // R9: success held until a start
  assert_up_held_R9: assert property (@(posedge clk) disable iff (rst)
    (link_up_o && !start_i) |=> link_up_o);

  // R9: failure held until a start
  assert_fail_held_R9: assert property (@(posedge clk) disable iff (rst)
    (link_failed_o && !start_i) |=> link_failed_o);

  // R3 / R4: a reset pulse only starts on a timeout tick
  assert_rst_rise_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(port_rst_o) |-> $past(tick_i));

  // R6: a reset pulse only ends on a tick
  assert_rst_fall_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(port_rst_o) |-> $past(tick_i));

  // R4: success only follows a seen link-active status
  assert_up_needs_active_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(link_up_o) |-> $past(lnk_active_i));

  // R7: failure only follows the end of a reset pulse
  assert_fail_after_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(link_failed_o) |-> ($past(port_rst_o) && !port_rst_o));

  // R10: no outcome while the port is held in reset
  assert_busy_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    port_rst_o |-> (!link_up_o && !link_failed_o));

  logic unused_ok;
  assign unused_ok = dl_up_i;
endmodule

bind link_bringup_mon lbm_checker u_lbm_checker (
  .clk           (clk),
  .rst           (rst),
  .start_i       (start_i),
  .tick_i        (tick_i),
  .dl_up_i       (dl_up_i),
  .lnk_active_i  (lnk_active_i),
  .port_rst_o    (port_rst_o),
  .link_up_o     (link_up_o),
  .link_failed_o (link_failed_o)
);

// File: tb/link_bringup_mon_bench.sv
`timescale 1ns/1ps
module link_bringup_mon_bench;
  localparam int TO = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic tick_i = 1'b0;
  logic dl_up_i = 1'b0;
  logic lnk_active_i = 1'b0;
  logic port_rst_o, link_up_o, link_failed_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  link_bringup_mon u_link_bringup_mon (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .tick_i        (tick_i),
    .dl_up_i       (dl_up_i),
    .lnk_active_i  (lnk_active_i),
    .port_rst_o    (port_rst_o),
    .link_up_o     (link_up_o),
    .link_failed_o (link_failed_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1; cyc(1); tick_i = 1'b0; cyc(1);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1; cyc(1); start_i = 1'b0;
  endtask

  task automatic do_reset();
    dl_up_i = 1'b0; lnk_active_i = 1'b0; tick_i = 1'b0; start_i = 1'b0;
    rst = 1'b1; cyc(3);
    chk("R1 port_rst in reset", port_rst_o, 1'b0);
    chk("R1 link_up in reset", link_up_o, 1'b0);
    chk("R1 link_failed in reset", link_failed_o, 1'b0);
    rst = 1'b0; cyc(1);
    chk("R1 port_rst after reset", port_rst_o, 1'b0);
  endtask

  // one attempt whose first wait times out, followed by the reset pulse
  task automatic dl_timeout_attempt(input bit last_one);
    ticks(TO - 1);
    chk("R3 no pulse before timeout", port_rst_o, 1'b0);
    chk("R10 up low while busy", link_up_o, 1'b0);
    ticks(1);
    chk("R3 pulse at timeout", port_rst_o, 1'b1);
    cyc(4);
    chk("R6 pulse held without tick", port_rst_o, 1'b1);
    chk("R10 failed low in pulse", link_failed_o, 1'b0);
    ticks(1);
    chk("R6 pulse ends after hold", port_rst_o, 1'b0);
    chk("R7 failure only after last", link_failed_o, last_one);
  endtask

  task automatic t_quick_success();
    do_reset();
    dl_up_i = 1'b1; lnk_active_i = 1'b1;
    pulse_start();
    chk("R10 busy after start", link_up_o, 1'b0);
    cyc(1);
    chk("R3 in second wait", link_up_o, 1'b0);
    cyc(1);
    chk("R4 success reported", link_up_o, 1'b1);
    chk("R9 not failed", link_failed_o, 1'b0);
    dl_up_i = 1'b0; lnk_active_i = 1'b0;
    ticks(5);
    chk("R9 success held", link_up_o, 1'b1);
    pulse_start();
    chk("R9 success clears on start", link_up_o, 1'b0);
  endtask

  task automatic t_all_fail();
    do_reset();
    pulse_start();
    for (int a = 1; a <= 3; a++) dl_timeout_attempt(a == 3);
    chk("R7 failed after three", link_failed_o, 1'b1);
    dl_up_i = 1'b1; lnk_active_i = 1'b1;
    ticks(3);
    chk("R9 failure held", link_failed_o, 1'b1);
    chk("R9 no success while held", link_up_o, 1'b0);
    chk("R9 no pulse while held", port_rst_o, 1'b0);
    dl_up_i = 1'b0; lnk_active_i = 1'b0;
    pulse_start();
    chk("R9 failure clears on start", link_failed_o, 1'b0);
  endtask

  task automatic t_third_try_success();
    do_reset();
    pulse_start();
    dl_timeout_attempt(1'b0);
    dl_timeout_attempt(1'b0);
    dl_up_i = 1'b1; lnk_active_i = 1'b1;
    cyc(2);
    chk("R7 success on last attempt", link_up_o, 1'b1);
    chk("R7 no failure on last success", link_failed_o, 1'b0);
  endtask

  task automatic t_second_wait_timeout();
    do_reset();
    pulse_start();
    ticks(150);
    dl_up_i = 1'b1;
    cyc(1);
    ticks(TO - 1);
    chk("R5 second wait full window", port_rst_o, 1'b0);
    ticks(1);
    chk("R4 pulse on second timeout", port_rst_o, 1'b1);
    ticks(1);
    chk("R6 pulse ends", port_rst_o, 1'b0);
    lnk_active_i = 1'b1;
    cyc(2);
    chk("R4 success on retry", link_up_o, 1'b1);
  endtask

  task automatic t_collision();
    do_reset();
    pulse_start();
    ticks(TO - 1);
    tick_i = 1'b1; dl_up_i = 1'b1; cyc(1); tick_i = 1'b0; cyc(1);
    chk("R8 status beats timeout first wait", port_rst_o, 1'b0);
    ticks(TO - 1);
    chk("R5 full window after collision", port_rst_o, 1'b0);
    tick_i = 1'b1; lnk_active_i = 1'b1; cyc(1); tick_i = 1'b0;
    chk("R8 status beats timeout second wait", link_up_o, 1'b1);
    chk("R8 no pulse", port_rst_o, 1'b0);
  endtask

  task automatic t_start_while_busy();
    do_reset();
    pulse_start();
    ticks(100);
    pulse_start();
    ticks(TO - 101);
    chk("R2 busy start ignored before", port_rst_o, 1'b0);
    ticks(1);
    chk("R2 busy start did not restart timer", port_rst_o, 1'b1);
  endtask

  initial begin
    cyc(2);
    t_quick_success();
    t_all_fail();
    t_third_try_success();
    t_second_wait_timeout();
    t_collision();
    t_start_while_busy();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule